// File: doc/BRIEF.md
# Prioritized Interrupt CPU Interface

This block is the per-processor half of an interrupt controller. A distributor outside the block picks the most urgent pending interrupt and presents its ID and 8-bit priority. The block filters that candidate through a programmable priority mask and through the priority of the handler now running. It then drives a single IRQ line to the processor core.

Software reaches the block through a small word-addressed register port. A read of the acknowledge register is a handshake. When a candidate is eligible, the read returns its ID, marks it active and raises the running priority to the priority of that interrupt. It also sends a one-cycle activate pulse with the ID to the distributor. When no candidate is eligible, the read returns the reserved spurious ID 1023 and changes nothing.

Software retires the handler by writing the acknowledged value to the end-of-interrupt register. The running priority then falls back to the level that was in force before the acknowledge. The distributor receives a one-cycle deactivate pulse with the ID. Active priorities are kept on a small stack, so a more urgent interrupt can preempt a handler that is already running.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the IRQ output is low, the control word reads 0, the mask reads 0x00 and the running priority reads 0xFF (idle).
- R2: Only the upper 5 bits of each 8-bit priority are kept. A write of 0xFF to the mask (word 1) reads back 0xF8, and the low 3 bits of any written mask read as zero.
- R3: The IRQ output is high exactly one cycle after a cycle that meets all of these conditions:
  - the enable (control word 0, bit 0) is set;
  - the distributor marks a candidate valid;
  - the truncated candidate priority is strictly below the mask;
  - the truncated candidate priority is strictly below the running priority.
- R4: A read of the acknowledge register (word 2) while a candidate is eligible has these effects:
  - the data returned holds the candidate ID in bits 9:0, with the upper bits zero;
  - the candidate's truncated priority becomes the running priority;
  - a one-cycle activate pulse carries the ID.
- R5: An acknowledge read while the block is disabled or no candidate is eligible returns 1023. It gives no activate pulse and leaves the running priority unchanged.
- R6: A write to the end-of-interrupt register (word 3) whose full 32-bit data equals the ID at the top of the active stack has these effects:
  - the running priority returns to the previous level, or to 0xFF when the stack empties;
  - a one-cycle deactivate pulse carries that ID.
- R7: An end-of-interrupt write whose data does not match the top-of-stack ID, or that arrives when the stack is empty, is ignored. It gives no deactivate pulse and the running priority is unchanged.
- R8: Reads of the running priority (word 4) and of the highest pending ID (word 5) have no side effects. Word 5 returns the candidate ID when one is valid and 1023 otherwise.
- R9: Up to 4 nested interrupts can be active. An acknowledge read while 4 are active returns 1023 and gives no activate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower value is more urgent |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq | output | 1 | Interrupt request to the core |
| act_pulse | output | 1 | One-cycle activate strobe to the distributor |
| act_id | output | 10 | ID carried by the activate strobe |
| deact_pulse | output | 1 | One-cycle deactivate strobe to the distributor |
| deact_id | output | 10 | ID carried by the deactivate strobe |

## Verification
The bench builds the block with its default parameters: a 10-bit ID, an 8-bit priority of which 5 bits are kept, and a stack 4 deep. With a stack of only 4, random sequences of acknowledge reads often fill the stack, which exercises the refusal when full. With 32 priority levels, a random candidate often sits equal to or just around the mask and the running priority, which exercises the strict comparisons. The directed part nests four interrupts at falling priorities and then retires them in reverse order. It also tries a fifth acknowledge and a mismatched end-of-interrupt while the stack is full.

// File: rtl/irqcif_pkg.sv
package irqcif_pkg;
  localparam int ID_W      = 10;
  localparam int PRIO_W    = 8;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_MASK    = 3'd1,
    RA_ACK     = 3'd2,
    RA_EOI     = 3'd3,
    RA_RUNNING = 3'd4,
    RA_PENDING = 3'd5
  } reg_addr_e;

  function automatic logic [PRIO_W-1:0] impl_mask(input int kept);
    logic [PRIO_W-1:0] m;
    for (int i = 0; i < PRIO_W; i++) m[i] = (i >= PRIO_W - kept);
    return m;
  endfunction
endpackage

// File: rtl/irqcif_stack.sv
module irqcif_stack #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [PRIO_W-1:0] top_prio,
  output logic [ID_W-1:0]   top_id,
  output logic              empty,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0][PRIO_W-1:0] prio_all;
  logic [DEPTH-1:0][ID_W-1:0]   id_all;
  logic [IDX_W-1:0] top_idx;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)       cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !empty)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gen_ent
    logic              wen;
    logic [PRIO_W-1:0] e_prio;
    logic [ID_W-1:0]   e_id;
    assign wen = push && !full && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_prio <= '0;
        e_id   <= '0;
      end else if (wen) begin
        e_prio <= push_prio;
        e_id   <= push_id;
      end
    end
    assign prio_all[i] = e_prio;
    assign id_all[i]   = e_id;
  end

  always_comb begin
    top_idx = IDX_W'(cnt_q - CNT_W'(1));
    if (empty) begin
      top_prio = '1;
      top_id   = '1;
    end else begin
      top_prio = prio_all[top_idx];
      top_id   = id_all[top_idx];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  push_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top_prio < $past(top_prio)));

  // R6
  pop_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/irqcif_elig.sv
module irqcif_elig #(
  parameter int PRIO_W = 8,
  parameter int KEPT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] running,
  output logic [PRIO_W-1:0] cand_prio_impl,
  output logic              eligible,
  output logic              irq
);
  localparam logic [PRIO_W-1:0] KEEP = irqcif_pkg::impl_mask(KEPT);

  logic irq_q, irq_d;

  assign cand_prio_impl = cand_prio & KEEP;

  always_comb begin
    eligible = cand_valid && (cand_prio_impl < mask) && (cand_prio_impl < running);
    irq_d    = en && eligible;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R3
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(en));
endmodule

// File: rtl/irqcif_regs.sv
module irqcif_regs
  import irqcif_pkg::*;
#(
  parameter int KEPT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              eligible,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio_impl,
  input  logic              stk_full,
  input  logic              stk_empty,
  input  logic [ID_W-1:0]   top_id,
  input  logic [PRIO_W-1:0] running,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] mask,
  output logic              push,
  output logic [ID_W-1:0]   push_id,
  output logic [PRIO_W-1:0] push_prio,
  output logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              act_pulse,
  output logic [ID_W-1:0]   act_id,
  output logic              deact_pulse,
  output logic [ID_W-1:0]   deact_id
);
  localparam logic [PRIO_W-1:0] KEEP     = impl_mask(KEPT);
  localparam logic [ID_W-1:0]   SPURIOUS = '1;

  logic              rd_en, wr_en;
  logic              en_q, en_d, en_we;
  logic [PRIO_W-1:0] mask_q, mask_d;
  logic              mask_we;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              act_q, deact_q;
  logic [ID_W-1:0]   act_id_q, deact_id_q;

  assign rd_en = bus_sel && !bus_wr;
  assign wr_en = bus_sel && bus_wr;

  always_comb begin
    en_we   = wr_en && (bus_addr == RA_CTRL);
    en_d    = bus_wdata[0];
    mask_we = wr_en && (bus_addr == RA_MASK);
    mask_d  = bus_wdata[PRIO_W-1:0] & KEEP;
    push    = rd_en && (bus_addr == RA_ACK) && en_q && eligible && !stk_full;
    push_id   = cand_id;
    push_prio = cand_prio_impl;
    pop     = wr_en && (bus_addr == RA_EOI) && !stk_empty &&
              (bus_wdata == DATA_W'(top_id));
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (bus_addr)
        RA_CTRL:    rdata_d = DATA_W'(en_q);
        RA_MASK:    rdata_d = DATA_W'(mask_q);
        RA_ACK:     rdata_d = push ? DATA_W'(cand_id) : DATA_W'(SPURIOUS);
        RA_RUNNING: rdata_d = DATA_W'(running);
        RA_PENDING: rdata_d = cand_valid ? DATA_W'(cand_id) : DATA_W'(SPURIOUS);
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      act_q      <= 1'b0;
      deact_q    <= 1'b0;
      act_id_q   <= '0;
      deact_id_q <= '0;
    end else begin
      rdata_q <= rdata_d;
      act_q   <= push;
      deact_q <= pop;
      if (push) act_id_q   <= cand_id;
      if (pop)  deact_id_q <= top_id;
    end
  end

  assign ctrl_en     = en_q;
  assign mask        = mask_q;
  assign rdata       = rdata_q;
  assign act_pulse   = act_q;
  assign act_id      = act_id_q;
  assign deact_pulse = deact_q;
  assign deact_id    = deact_id_q;

  // R5
  act_not_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (rdata_q[ID_W-1:0] != SPURIOUS));

  // R6
  pulses_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_q && deact_q));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irqcif_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int KEPT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              act_pulse,
  output logic [ID_W-1:0]   act_id,
  output logic              deact_pulse,
  output logic [ID_W-1:0]   deact_id
);
  logic              ctrl_en, eligible, push, pop, stk_full, stk_empty;
  logic [PRIO_W-1:0] mask, running, prio_impl, push_prio;
  logic [ID_W-1:0]   push_id, top_id;

  irqcif_elig #(.PRIO_W(PRIO_W), .KEPT(KEPT)) u_elig (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cand_valid(cand_valid),
    .cand_prio(cand_prio), .mask(mask), .running(running),
    .cand_prio_impl(prio_impl), .eligible(eligible), .irq(irq)
  );

  irqcif_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_id(push_id),
    .push_prio(push_prio), .pop(pop), .top_prio(running), .top_id(top_id),
    .empty(stk_empty), .full(stk_full)
  );

  irqcif_regs #(.KEPT(KEPT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .eligible(eligible),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio_impl(prio_impl),
    .stk_full(stk_full), .stk_empty(stk_empty), .top_id(top_id),
    .running(running), .ctrl_en(ctrl_en), .mask(mask), .push(push),
    .push_id(push_id), .push_prio(push_prio), .pop(pop), .rdata(bus_rdata),
    .act_pulse(act_pulse), .act_id(act_id), .deact_pulse(deact_pulse),
    .deact_id(deact_id)
  );
endmodule

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, act_pulse, deact_pulse;
  logic [9:0]  act_id, deact_id;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  bit        m_en = 0;
  logic [7:0] m_mask = 8'h00;
  int        m_cnt = 0;
  logic [7:0] m_sp [4];
  logic [9:0] m_sid [4];

  always #10 clk = ~clk;

  irq_cpu_if u_dut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .act_pulse(act_pulse), .act_id(act_id),
    .deact_pulse(deact_pulse), .deact_id(deact_id)
  );

  function automatic logic [7:0] m_run();
    return (m_cnt == 0) ? 8'hFF : m_sp[m_cnt-1];
  endfunction

  function automatic bit m_elig(bit v, logic [7:0] p);
    logic [7:0] t = p & 8'hF8;
    return v && (t < m_mask) && (t < m_run());
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op: 0 idle, 1 read, 2 write
  task automatic step(int op, logic [2:0] a, logic [31:0] d);
    bit e_irq, e_act, e_deact, chk_rd;
    logic [9:0] e_aid, e_did;
    logic [31:0] e_rd;
    string rreq;
    bus_sel = (op != 0); bus_wr = (op == 2); bus_addr = a; bus_wdata = d;
    e_irq = m_en && m_elig(cand_valid, cand_prio);
    e_act = 0; e_deact = 0; chk_rd = 0; e_aid = '0; e_did = '0; e_rd = '0;
    rreq = "R8";
    if (op == 1) begin
      chk_rd = 1;
      case (a)
        3'd0: begin e_rd = {31'b0, m_en}; rreq = "R1"; end
        3'd1: begin e_rd = {24'b0, m_mask}; rreq = "R2"; end
        3'd2: begin
          if (m_en && m_elig(cand_valid, cand_prio) && m_cnt < 4) begin
            e_rd = {22'b0, cand_id}; e_act = 1; e_aid = cand_id; rreq = "R4";
            m_sp[m_cnt] = cand_prio & 8'hF8; m_sid[m_cnt] = cand_id; m_cnt++;
          end else begin
            e_rd = 32'd1023; rreq = (m_cnt == 4) ? "R9" : "R5";
          end
        end
        3'd4: e_rd = {24'b0, m_run()};
        3'd5: e_rd = cand_valid ? {22'b0, cand_id} : 32'd1023;
        default: e_rd = '0;
      endcase
    end else if (op == 2) begin
      case (a)
        3'd0: m_en = d[0];
        3'd1: m_mask = d[7:0] & 8'hF8;
        3'd3: if (m_cnt > 0 && d == {22'b0, m_sid[m_cnt-1]}) begin
          e_deact = 1; e_did = m_sid[m_cnt-1]; m_cnt--;
        end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check("R3 irq", {31'b0, irq}, {31'b0, e_irq});
    check("R4 act_pulse", {31'b0, act_pulse}, {31'b0, e_act});
    if (e_act) check("R4 act_id", {22'b0, act_id}, {22'b0, e_aid});
    check((op == 2 && a == 3'd3 && !e_deact) ? "R7 deact_pulse" : "R6 deact_pulse",
          {31'b0, deact_pulse}, {31'b0, e_deact});
    if (e_deact) check("R6 deact_id", {22'b0, deact_id}, {22'b0, e_did});
    if (chk_rd) check(rreq, bus_rdata, e_rd);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic set_cand(bit v, logic [9:0] id, logic [7:0] p);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int s;
    s = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1 reset state seen while still in reset
    check("R1 irq", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 3'd0, 0);               // R1 ctrl
    step(1, 3'd1, 0);               // R1 mask
    step(1, 3'd4, 0);               // R1 running idle
    // R2 mask width probe
    step(2, 3'd1, 32'hFF);
    step(1, 3'd1, 0);
    step(2, 3'd1, 32'h57);
    step(1, 3'd1, 0);
    // R5 disabled acknowledge
    set_cand(1, 10'd33, 8'h10);
    step(2, 3'd1, 32'hFF);
    step(1, 3'd2, 0);
    step(2, 3'd0, 32'h1);
    step(0, 3'd0, 0);
    // R3 boundary: prio equal to mask is blocked
    step(2, 3'd1, 32'h40);
    set_cand(1, 10'd40, 8'h47);     // truncates to 0x40, not below mask
    step(0, 3'd0, 0);
    step(1, 3'd2, 0);               // R5
    set_cand(1, 10'd41, 8'h3F);     // 0x38 < 0x40
    step(0, 3'd0, 0);
    step(2, 3'd1, 32'hFF);
    // R9 nesting four deep
    set_cand(1, 10'd5, 8'hF0); step(1, 3'd2, 0);
    set_cand(1, 10'd6, 8'hA3); step(1, 3'd2, 0);
    set_cand(1, 10'd7, 8'hA0); step(1, 3'd2, 0);  // equal to running: R5
    set_cand(1, 10'd7, 8'h60); step(1, 3'd2, 0);
    set_cand(1, 10'd8, 8'h20); step(1, 3'd2, 0);
    set_cand(1, 10'd9, 8'h00); step(0, 3'd0, 0);
    step(1, 3'd2, 0);               // R9 full -> spurious
    step(1, 3'd4, 0);               // R8 running 0x20
    step(1, 3'd5, 0);               // R8 pending
    step(2, 3'd3, 32'd5);           // R7 mismatch
    step(2, 3'd3, 32'h400 | 32'd8); // R7 upper bits set
    step(1, 3'd4, 0);
    set_cand(0, 10'd0, 8'h00);
    step(1, 3'd5, 0);               // R8 no candidate
    step(2, 3'd3, 32'd8); step(1, 3'd4, 0);
    step(2, 3'd3, 32'd7); step(2, 3'd3, 32'd6);
    step(2, 3'd3, 32'd5); step(1, 3'd4, 0);
    step(2, 3'd3, 32'd5);           // R7 empty stack
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int k = $urandom_range(0, 3);
      set_cand($urandom_range(0, 9) != 0, 10'($urandom_range(0, 1022)),
               8'($urandom_range(0, 255)));
      if (r < 35)      step(1, 3'd2, 0);
      else if (r < 60) step(2, 3'd3, (m_cnt > 0 && k != 0) ? {22'b0, m_sid[m_cnt-1]}
                                        : 32'($urandom_range(0, 1023)));
      else if (r < 66) step(2, 3'd1, 32'($urandom_range(0, 255)) | 32'h80);
      else if (r < 69) step(2, 3'd0, 32'($urandom_range(0, 3) != 0));
      else if (r < 78) step(1, 3'd4, 0);
      else if (r < 84) step(1, 3'd5, 0);
      else if (r < 88) step(1, 3'd1, 0);
      else             step(0, 3'd0, 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule